// File: doc/BRIEF.md
# Rotating Event-Memory Contribution Scheduler

This block serves one station of a wide sieving pipeline. It holds many sparse progressions whose intervals are long compared with the pipeline width. Each progression is kept as an event record made of its interval, the next index it hits, and the weight it adds at that index. The records sit in a circular memory, one row per group of `LANES` consecutive indices. Each row has a few slack entries that absorb collisions.

Before a run, software-side logic loads the initial events while the station is idle, relative to a base row. A start pulse then sets a read head going around the memory, one entry per clock. For each occupied entry the block emits a contribution naming the lane (index modulo `LANES`) and the weight. It then advances the index by the interval and writes the event back into the row that the head will reach when the new index comes due.

The head rotation takes the place of a true priority queue. Rows that have been consumed are reused for events due up to `ROWS-1` rows later. An event that cannot be placed is dropped and reported by a one-cycle flag.

Top module: `cyc_event_sched`

## Requirements
- R1: Reset leaves every memory entry empty, the head idle, and `ctr_valid`, `ovf_pulse` and `range_err` low.
- R2: While idle, a load with index a is placed in physical row (a >> log2(LANES)) mod ROWS when the absolute row a >> log2(LANES) minus `base_row` lies in 0..ROWS-1; otherwise `range_err` is high in the cycle after the load, and the event is dropped.
- R3: A start pulse while idle makes the head visit absolute rows `base_row`, `base_row`+1, and so on, one entry per cycle, entries 0..SLACK-1 of each row in rising order. The entry read k cycles after the start edge has its result on the outputs after edge k+2.
- R4: An occupied entry yields `ctr_valid` high, `ctr_lane` equal to the low log2(LANES) bits of its index, and `ctr_weight` equal to its stored weight. The event is rewritten with index a+p (modulo 2^IDX_W).
- R5: A placed event (load or rewrite) takes the lowest-numbered free entry of its target row.
- R6: When every entry of the target row is occupied, `ovf_pulse` is high for one cycle (timed like R2 for loads and like R3 for rewrites) and the event is dropped.
- R7: During a run, a rewritten event whose new absolute row minus the absolute row of the entry just consumed is not within 2..ROWS-1 raises `range_err` (timed like R3) and is dropped.
- R8: Reading an empty entry produces no contribution and raises no flag.
- R9: Loads presented while the head is running are ignored.
- R10: `ovf_pulse` and `range_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load an initial event this cycle (idle only) |
| ld_index | input | IDX_W | Index of the event's next hit |
| ld_interval | input | INT_W | Progression interval |
| ld_weight | input | WT_W | Weight added at each hit |
| base_row | input | IDX_W-log2(LANES) | Absolute row of the head at start and reference for loads |
| start | input | 1 | Begin rotating the head from `base_row` |
| ctr_valid | output | 1 | Contribution present |
| ctr_lane | output | log2(LANES) | Pipeline lane of the contribution |
| ctr_weight | output | WT_W | Weight of the contribution |
| ovf_pulse | output | 1 | Event dropped: target row full |
| range_err | output | 1 | Event dropped: target row outside the window |

## Verification
A table of initial events is loaded. It includes three events aimed at one row, so that the third overflows, plus one event beyond the window and one behind the base. These loads show the placement path and both drop paths apart. During the run, a behavioural scoreboard follows every entry the head reads and predicts each contribution and flag cycle by cycle. The intervals are chosen so that rewrites collide in one row, land too close (delta 1) or too far (delta 17), and wrap around the circular memory. This tells apart the slack selection, the window test and the reuse of consumed rows. A load injected mid-run, and a fresh start after reset with nothing loaded, confirm that loads are ignored while running and that empty entries stay silent.

// File: rtl/cyc_sched_pkg.sv
package cyc_sched_pkg;
  // outcome of one placement attempt
  typedef enum logic [1:0] {
    PLACE_NONE  = 2'd0,
    PLACE_OK    = 2'd1,
    PLACE_FULL  = 2'd2,
    PLACE_RANGE = 2'd3
  } place_e;
endpackage

// File: rtl/cyc_slot_calc.sv
// Target-row window test: new absolute row relative to a reference row.
module cyc_slot_calc #(
  parameter int ROWS   = 16,
  parameter int ROW_W  = 4,
  parameter int ROWA_W = 14
) (
  input  logic [ROWA_W-1:0] new_row_abs,
  input  logic [ROWA_W-1:0] ref_row_abs,
  input  logic              run_mode,
  output logic              in_window,
  output logic [ROW_W-1:0]  tgt_row
);
  logic [ROWA_W-1:0] delta;
  logic [ROWA_W-1:0] lo;

  always_comb begin
    delta     = new_row_abs - ref_row_abs;
    lo        = run_mode ? ROWA_W'(2) : '0;
    in_window = (delta >= lo) && (delta <= ROWA_W'(ROWS - 1));
    tgt_row   = new_row_abs[ROW_W-1:0];
  end
endmodule

// File: rtl/cyc_free_pick.sv
// Lowest free slack entry of a row.
module cyc_free_pick #(
  parameter int SLACK = 2,
  parameter int SLK_W = 1
) (
  input  logic [SLACK-1:0] occ,
  output logic             found,
  output logic [SLK_W-1:0] sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = SLACK - 1; k >= 0; k--) begin
      if (!occ[k]) begin
        found = 1'b1;
        sel   = SLK_W'(k);
      end
    end
  end
endmodule

// File: rtl/cyc_event_ram.sv
// Simple dual-port memory, registered read, suitable for block RAM.
module cyc_event_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 34
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/cyc_event_sched.sv
module cyc_event_sched #(
  parameter int LANES = 4,
  parameter int ROWS  = 16,
  parameter int SLACK = 2,
  parameter int IDX_W = 16,
  parameter int INT_W = 12,
  parameter int WT_W  = 6,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROWA_W = IDX_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_index,
  input  logic [INT_W-1:0]  ld_interval,
  input  logic [WT_W-1:0]   ld_weight,
  input  logic [ROWA_W-1:0] base_row,
  input  logic              start,
  output logic              ctr_valid,
  output logic [LANE_W-1:0] ctr_lane,
  output logic [WT_W-1:0]   ctr_weight,
  output logic              ovf_pulse,
  output logic              range_err
);
  import cyc_sched_pkg::*;

  localparam int ROW_W = $clog2(ROWS);
  localparam int SLK_W = (SLACK > 1) ? $clog2(SLACK) : 1;
  localparam int AW    = ROW_W + SLK_W;
  localparam int DEPTH = ROWS << SLK_W;
  localparam int DW    = INT_W + IDX_W + WT_W;

  // head state
  logic              running_q;
  logic [ROWA_W-1:0] hd_row_q;
  logic [SLK_W-1:0]  hd_slk_q;
  logic [AW-1:0]     rd_addr;

  // occupancy
  logic [DEPTH-1:0]  vld_q;

  // stage 1 (entry read last cycle)
  logic              act1_q;
  logic              v1_q;
  logic [ROWA_W-1:0] row1_q;
  logic [DW-1:0]     rd_data;
  logic [INT_W-1:0]  rd_interval;
  logic [IDX_W-1:0]  rd_index;
  logic [WT_W-1:0]   rd_weight;

  // placement path
  logic              ins_req;
  logic [IDX_W-1:0]  ins_idx;
  logic [INT_W-1:0]  ins_interval;
  logic [WT_W-1:0]   ins_weight;
  logic [ROWA_W-1:0] ins_ref;
  logic              in_window;
  logic [ROW_W-1:0]  tgt_row;
  logic [SLACK-1:0]  occ;
  logic              found;
  logic [SLK_W-1:0]  sel;
  logic              we;
  logic [AW-1:0]     wa;
  logic [DW-1:0]     wd;
  place_e            place_res;

  assign rd_addr = {hd_row_q[ROW_W-1:0], hd_slk_q};
  assign {rd_interval, rd_index, rd_weight} = rd_data;

  always_comb begin
    if (running_q) begin
      ins_req      = act1_q & v1_q;
      ins_idx      = rd_index + IDX_W'(rd_interval);
      ins_interval = rd_interval;
      ins_weight   = rd_weight;
      ins_ref      = row1_q;
    end else begin
      ins_req      = ld_valid;
      ins_idx      = ld_index;
      ins_interval = ld_interval;
      ins_weight   = ld_weight;
      ins_ref      = base_row;
    end
  end

  cyc_slot_calc #(.ROWS(ROWS), .ROW_W(ROW_W), .ROWA_W(ROWA_W)) u_slot (
    .new_row_abs (ins_idx[IDX_W-1:LANE_W]),
    .ref_row_abs (ins_ref),
    .run_mode    (running_q),
    .in_window   (in_window),
    .tgt_row     (tgt_row)
  );

  for (genvar k = 0; k < SLACK; k++) begin : g_occ
    assign occ[k] = vld_q[{tgt_row, SLK_W'(k)}];
  end

  cyc_free_pick #(.SLACK(SLACK), .SLK_W(SLK_W)) u_pick (
    .occ   (occ),
    .found (found),
    .sel   (sel)
  );

  always_comb begin
    if (!ins_req)        place_res = PLACE_NONE;
    else if (!in_window) place_res = PLACE_RANGE;
    else if (!found)     place_res = PLACE_FULL;
    else                 place_res = PLACE_OK;
  end

  assign we = (place_res == PLACE_OK);
  assign wa = {tgt_row, sel};
  assign wd = {ins_interval, ins_idx, ins_weight};

  cyc_event_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ram (
    .clk (clk),
    .we  (we),
    .wa  (wa),
    .wd  (wd),
    .ra  (rd_addr),
    .rq  (rd_data)
  );

  // head rotation
  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      hd_row_q  <= '0;
      hd_slk_q  <= '0;
    end else if (!running_q) begin
      if (start) begin
        running_q <= 1'b1;
        hd_row_q  <= base_row;
        hd_slk_q  <= '0;
      end
    end else begin
      hd_slk_q <= hd_slk_q + 1'b1;
      if (hd_slk_q == SLK_W'(SLACK - 1)) hd_row_q <= hd_row_q + 1'b1;
    end
  end

  // occupancy: clear on read, set on placement (never the same row)
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (running_q) vld_q[rd_addr] <= 1'b0;
      if (we)        vld_q[wa]      <= 1'b1;
    end
  end

  // stage 1 bookkeeping alongside the registered memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      act1_q <= 1'b0;
      v1_q   <= 1'b0;
      row1_q <= '0;
    end else begin
      act1_q <= running_q;
      v1_q   <= running_q & vld_q[rd_addr];
      row1_q <= hd_row_q;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_valid  <= 1'b0;
      ctr_lane   <= '0;
      ctr_weight <= '0;
      ovf_pulse  <= 1'b0;
      range_err  <= 1'b0;
    end else begin
      ctr_valid <= act1_q & v1_q & running_q;
      if (act1_q & v1_q & running_q) begin
        ctr_lane   <= rd_index[LANE_W-1:0];
        ctr_weight <= rd_weight;
      end
      ovf_pulse <= (place_res == PLACE_FULL);
      range_err <= (place_res == PLACE_RANGE);
    end
  end
endmodule

// File: rtl/cyc_event_sched_chk.sv
module cyc_event_sched_chk #(
  parameter int SLK_W  = 1,
  parameter int ROWA_W = 14,
  parameter int SLACK  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              running_q,
  input logic              act1_q,
  input logic              v1_q,
  input logic [SLK_W-1:0]  hd_slk_q,
  input logic [ROWA_W-1:0] hd_row_q,
  input logic              we,
  input logic              ctr_valid,
  input logic              ovf_pulse,
  input logic              range_err
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_pulse && range_err)); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !act1_q |=> !ctr_valid); // R3

  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (rst)
    (act1_q && !v1_q) |=> !ctr_valid && !ovf_pulse && !range_err); // R8

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    running_q |=> running_q && (hd_slk_q == SLK_W'($past(hd_slk_q) + 1'b1))); // R3

  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (running_q && hd_slk_q == SLK_W'(SLACK - 1)) |=> hd_row_q == ROWA_W'($past(hd_row_q) + 1'b1)); // R3

  AST_NO_LOAD_RUN: assert property (@(posedge clk) disable iff (rst)
    (running_q && !(act1_q && v1_q)) |-> !we); // R9
endmodule

bind cyc_event_sched cyc_event_sched_chk #(.SLK_W(SLK_W), .ROWA_W(ROWA_W), .SLACK(SLACK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .running_q (running_q),
  .act1_q    (act1_q),
  .v1_q      (v1_q),
  .hd_slk_q  (hd_slk_q),
  .hd_row_q  (hd_row_q),
  .we        (we),
  .ctr_valid (ctr_valid),
  .ovf_pulse (ovf_pulse),
  .range_err (range_err)
);

// File: tb/sim_cyc_event_sched.sv
module sim_cyc_event_sched;
  localparam int LANES = 4, ROWS = 16, SLACK = 2;
  localparam int IDX_W = 16, INT_W = 12, WT_W = 6;
  localparam int ROWA_W = 14, NENT = ROWS * SLACK;
  localparam int BASE = 5, RUN_CYC = 96;
  localparam int NLOAD = 11;
  // {index, interval, weight}
  localparam logic [33:0] LOAD_TAB [NLOAD] = '{
    {16'd20, 12'd12, 6'd3},  {16'd21, 12'd9,  6'd4},  {16'd22, 12'd8,  6'd5},
    {16'd30, 12'd5,  6'd6},  {16'd33, 12'd70, 6'd7},  {16'd44, 12'd60, 6'd8},
    {16'd90, 12'd3,  6'd9},  {16'd19, 12'd3,  6'd13}, {16'd40, 12'd13, 6'd10},
    {16'd41, 12'd11, 6'd11}, {16'd45, 12'd8,  6'd12}
  };

  logic clk = 0, rst = 1;
  logic ld_valid = 0, start = 0;
  logic [IDX_W-1:0] ld_index = '0;
  logic [INT_W-1:0] ld_interval = '0;
  logic [WT_W-1:0] ld_weight = '0;
  logic [ROWA_W-1:0] base_row = '0;
  logic ctr_valid, ovf_pulse, range_err;
  logic [1:0] ctr_lane;
  logic [WT_W-1:0] ctr_weight;

  int checks = 0, errors = 0;
  int mv[NENT], mi[NENT], mp[NENT], mw[NENT];
  int seen_valid = 0, seen_ovf = 0, seen_rng = 0;

  always #5 clk = ~clk;

  cyc_event_sched u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // placement per R2/R5/R6/R7: 0 placed, 1 full, 2 out of window
  function automatic int place(int idx, int refr, bit runm, int p, int w);
    int delta, row;
    delta = ((idx >> 2) - refr) & 16'h3fff;
    if (delta < (runm ? 2 : 0) || delta > ROWS - 1) return 2;
    row = (idx >> 2) & (ROWS - 1);
    for (int k = 0; k < SLACK; k++)
      if (mv[row*SLACK+k] == 0) begin
        mv[row*SLACK+k] = 1; mi[row*SLACK+k] = idx; mp[row*SLACK+k] = p; mw[row*SLACK+k] = w;
        return 0;
      end
    return 1;
  endfunction

  task automatic check_quiet(input string tag);
    chk(ctr_valid == 0, {tag, " ctr_valid"}, ctr_valid, 0);
    chk(ovf_pulse == 0, {tag, " ovf_pulse"}, ovf_pulse, 0);
    chk(range_err == 0, {tag, " range_err"}, range_err, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NENT; k++) mv[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check_quiet("R1 reset");

    // loads while idle (R2, R5, R6)
    base_row = ROWA_W'(BASE);
    for (int n = 0; n < NLOAD; n++) begin
      int r;
      ld_valid = 1;
      {ld_index, ld_interval, ld_weight} = LOAD_TAB[n];
      r = place(int'(ld_index), BASE, 0, int'(ld_interval), int'(ld_weight));
      @(posedge clk); #1;
      chk(ovf_pulse == (r == 1), "R6 load overflow", ovf_pulse, r == 1);
      chk(range_err == (r == 2), "R2 load window", range_err, r == 2);
      chk(ctr_valid == 0, "R2 no contribution on load", ctr_valid, 0);
    end
    ld_valid = 0;

    // run (R3, R4, R5, R6, R7, R8, R9, R10)
    start = 1;
    @(posedge clk); #1;
    start = 0;
    for (int c = 1; c <= RUN_CYC; c++) begin
      bit ev; int el, ew, eo, er;
      @(posedge clk); #1;
      ev = 0; el = 0; ew = 0; eo = 0; er = 0;
      if (c >= 2) begin
        int e, rowa, a, r;
        e = c - 2;
        rowa = BASE + e / SLACK;
        a = (rowa % ROWS) * SLACK + e % SLACK;
        if (mv[a] != 0) begin
          ev = 1; el = mi[a] & 3; ew = mw[a];
          mv[a] = 0;
          r = place((mi[a] + mp[a]) & 16'hffff, rowa, 1, mp[a], mw[a]);
          eo = (r == 1); er = (r == 2);
        end
      end
      chk(ctr_valid == ev, "R3,R4,R5,R8 ctr_valid", ctr_valid, ev);
      if (ev && ctr_valid) begin
        chk(ctr_lane == el, "R4 lane", ctr_lane, el);
        chk(ctr_weight == ew, "R4 weight", ctr_weight, ew);
      end
      chk(ovf_pulse == eo, "R6 run overflow", ovf_pulse, eo);
      chk(range_err == er, "R7 run window", range_err, er);
      chk(!(ovf_pulse && range_err), "R10 exclusive flags", ovf_pulse + range_err, 1);
      seen_valid += ctr_valid; seen_ovf += ovf_pulse; seen_rng += range_err;
      // R9: a load during the run must not appear anywhere
      if (c == 10) begin
        ld_valid = 1; ld_index = 16'd68; ld_interval = 12'd8; ld_weight = 6'd63;
      end
      if (c == 11) ld_valid = 0;
    end
    chk(seen_valid > 8, "R4 rewritten events reappear", seen_valid, 9);
    chk(seen_ovf >= 1, "R6 overflow exercised", seen_ovf, 1);
    chk(seen_rng >= 1, "R7 window error exercised", seen_rng, 1);

    // reset mid-run, then start with nothing loaded (R1, R8)
    rst = 1;
    @(posedge clk); @(posedge clk); #1;
    check_quiet("R1 reset during run");
    rst = 0;
    base_row = '0;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    for (int c = 1; c <= 40; c++) begin
      @(posedge clk); #1;
      check_quiet("R1,R8 empty after reset");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule